// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block accepts a three-wire serial stream (a bit line, a bit clock and a load strobe) and turns it into the settings of a frequency synthesizer. Each bit is taken on a rising edge of the serial clock, most significant bit first, into one 19-bit shift register. All three serial lines are asynchronous to the system clock. Each passes through a synchronizer stage, and its edges are detected in the system clock domain before any bit is sampled.

A rising edge of the load strobe copies the register into one of two holding registers. The choice depends on the bit shifted in last. A one selects the reference word. This word is 18 bits and carries the reference division ratio, the prescaler choice, the run/power-save request and the choice of signal for the shared monitor output. A zero selects the divider word. This word is 19 bits and carries the main counter preset and the swallow counter preset.

A word whose ratio lies below its legal floor is discarded. The holding register keeps its old contents, and a sticky error flag is raised that only reset clears.

Top module: `synth_cfg_loader`

## Requirements
- R1: After reset, ref_ratio is 6, main_ratio is 5, swallow is 0, and pre_small, run_en, mon_sel and cfg_err are all 0.
- R2: One bit of ser_data is taken per rising edge of ser_clk, most significant bit first. Shifting with no load strobe changes no output.
- R3: On a load strobe rising edge with the last shifted bit at 1, only the reference fields may change. main_ratio and swallow hold.
- R4: On a load strobe rising edge with the last shifted bit at 0, only main_ratio and swallow may change. The reference fields hold.
- R5: In the reference word, counted from the last bit shifted in as bit 0: bit 17 is mon_sel, bit 16 is run_en (1 = normal operation, 0 = power save), bit 15 is pre_small (1 = the small prescaler ratio pair), and bits 14..1 are ref_ratio.
- R6: In the divider word, counted the same way: bits 18..8 are main_ratio and bits 7..1 are swallow.
- R7: A transfer happens once for each rising edge of the load strobe. Bits shifted while the strobe stays high do not reach the outputs until the next rising edge.
- R8: For a reference word, the register bit above bit 17 is ignored. A stale 1 left there from an earlier word does not affect any field.
- R9: A reference word with ratio below 6 leaves all reference fields unchanged and sets cfg_err.
- R10: A divider word with main ratio below 5 leaves main_ratio and swallow unchanged and sets cfg_err.
- R11: cfg_err stays at 1 through later valid loads until reset.
- R12: A reference ratio of 6, a main ratio of 5 and a swallow value of 0 are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial bit line, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 14 | Reference divider ratio |
| pre_small | output | 1 | Prescaler selection |
| run_en | output | 1 | 1 = normal operation, 0 = power save |
| mon_sel | output | 1 | 1 = monitor signal on the shared output, 0 = lock indicator |
| main_ratio | output | 11 | Main counter preset |
| swallow | output | 7 | Swallow counter preset |
| cfg_err | output | 1 | Sticky flag for a rejected ratio |

## Verification
The hardest case to reach is the 18-bit reference word loaded over a register whose top bit is still 1. The stimulus sends a reference word, which ends in a 1, and follows it with a second reference word of exactly 18 bits. That 1 then sits in the ignored bit while the new monitor bit is 0. A second case holds the strobe high while three more bits are clocked in, so the outputs must stay frozen until the strobe rises again. A third case sends a rejected ratio right after an accepted one, which shows that the old values survive alongside the error flag.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   localparam int REF_RW     = 14;
   localparam int SWAL_W     = 7;
   localparam int MAIN_W     = 11;
   localparam int REF_WORD_W = REF_RW + 4;
   localparam int DIV_WORD_W = MAIN_W + SWAL_W + 1;
   localparam int SR_W       = (REF_WORD_W > DIV_WORD_W) ? REF_WORD_W : DIV_WORD_W;

   typedef struct packed {
      logic              mon_sel;
      logic              run_en;
      logic              pre_small;
      logic [REF_RW-1:0] ratio;
   } ref_cfg_t;

   typedef struct packed {
      logic [MAIN_W-1:0] main;
      logic [SWAL_W-1:0] swal;
   } div_cfg_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_depth
      $error("scl_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/scl_shreg.sv
module scl_shreg #(
   parameter int W = 19
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_width
      $error("scl_shreg width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (shift_en) q <= {q[W-2:0], din};
   end

   // R2
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> q[0] == $past(din));
   // R2
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(q));
endmodule

// File: rtl/scl_latch.sv
module scl_latch
   import synth_cfg_pkg::*;
#(
   parameter int REF_MIN  = 6,
   parameter int MAIN_MIN = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [SR_W-1:0] sr,
   output ref_cfg_t        ref_q,
   output div_cfg_t        div_q,
   output logic            err_q
);
   if (REF_MIN < 1 || REF_MIN >= (1 << REF_RW)) begin : g_bad_ref
      $error("REF_MIN out of field range");
   end
   if (MAIN_MIN < 1 || MAIN_MIN >= (1 << MAIN_W)) begin : g_bad_main
      $error("MAIN_MIN out of field range");
   end

   ref_cfg_t ref_cand;
   div_cfg_t div_cand;
   logic     sel_ref;
   logic     ref_ok;
   logic     div_ok;

   assign sel_ref  = sr[0];
   assign ref_cand = ref_cfg_t'(sr[REF_WORD_W-1:1]);
   assign div_cand = div_cfg_t'(sr[DIV_WORD_W-1:1]);
   assign ref_ok   = int'(ref_cand.ratio) >= REF_MIN;
   assign div_ok   = int'(div_cand.main) >= MAIN_MIN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '{mon_sel: 1'b0, run_en: 1'b0, pre_small: 1'b0,
                    ratio: REF_RW'(REF_MIN)};
         div_q <= '{main: MAIN_W'(MAIN_MIN), swal: '0};
         err_q <= 1'b0;
      end else if (load) begin
         if (sel_ref) begin
            if (ref_ok) ref_q <= ref_cand;
            else        err_q <= 1'b1;
         end else begin
            if (div_ok) div_q <= div_cand;
            else        err_q <= 1'b1;
         end
      end
   end

   // R3
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sr[0]) |=> $stable(div_q));
   // R4
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !sr[0]) |=> $stable(ref_q));
   // R9
   ref_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && sr[0] && int'(sr[REF_RW:1]) < REF_MIN) |=> ($stable(ref_q) && err_q));
   // R10
   div_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !sr[0] && int'(sr[DIV_WORD_W-1:SWAL_W+1]) < MAIN_MIN) |=> ($stable(div_q) && err_q));
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R7
   no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(ref_q) && $stable(div_q)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
   import synth_cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REF_MIN     = 6,
   parameter int MAIN_MIN    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   output logic [REF_RW-1:0] ref_ratio,
   output logic              pre_small,
   output logic              run_en,
   output logic              mon_sel,
   output logic [MAIN_W-1:0] main_ratio,
   output logic [SWAL_W-1:0] swallow,
   output logic              cfg_err
);
   localparam int N_LINES = 3;

   logic [N_LINES-1:0] raw_in;
   logic [N_LINES-1:0] lvl_s;
   logic [N_LINES-1:0] rise_s;
   logic [SR_W-1:0]    sr;
   ref_cfg_t           ref_q;
   div_cfg_t           div_q;

   assign raw_in = {ser_le, ser_data, ser_clk};

   for (genvar i = 0; i < N_LINES; i++) begin : g_sync
      scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .rst_n (rst_n),
         .din (raw_in[i]),
         .lvl (lvl_s[i]),
         .rise (rise_s[i])
      );
   end

   scl_shreg #(.W(SR_W)) u_shreg (
      .clk (clk),
      .rst_n (rst_n),
      .shift_en (rise_s[0]),
      .din (lvl_s[1]),
      .q (sr)
   );

   scl_latch #(.REF_MIN(REF_MIN), .MAIN_MIN(MAIN_MIN)) u_latch (
      .clk (clk),
      .rst_n (rst_n),
      .load (rise_s[2]),
      .sr (sr),
      .ref_q (ref_q),
      .div_q (div_q),
      .err_q (cfg_err)
   );

   assign ref_ratio  = ref_q.ratio;
   assign pre_small  = ref_q.pre_small;
   assign run_en     = ref_q.run_en;
   assign mon_sel    = ref_q.mon_sel;
   assign main_ratio = div_q.main;
   assign swallow    = div_q.swal;

   // R1
   floor_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ref_ratio) >= REF_MIN);
   // R12
   floor_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(main_ratio) >= MAIN_MIN);
endmodule

// File: tb/sim_synth_cfg_loader.sv
module sim_synth_cfg_loader;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic [13:0] ref_ratio;
   logic pre_small, run_en, mon_sel, cfg_err;
   logic [10:0] main_ratio;
   logic [6:0]  swallow;

   always #2 clk = ~clk;

   synth_cfg_loader u0 (
      .clk (clk), .rst_n (rst_n), .ser_clk (ser_clk), .ser_data (ser_data),
      .ser_le (ser_le), .ref_ratio (ref_ratio), .pre_small (pre_small),
      .run_en (run_en), .mon_sel (mon_sel), .main_ratio (main_ratio),
      .swallow (swallow), .cfg_err (cfg_err)
   );

   int checks = 0, errors = 0, settle = 0;
   bit done = 0;
   bit bits_q[$];
   int m_ratio, m_pre, m_run, m_mon, m_main, m_swal, m_err;

   function automatic longint act_vec();
      return {mon_sel, run_en, pre_small, ref_ratio, main_ratio, swallow, cfg_err};
   endfunction
   function automatic longint exp_vec();
      logic [35:0] v;
      v = {m_mon[0], m_run[0], m_pre[0], 14'(m_ratio), 11'(m_main), 7'(m_swal), m_err[0]};
      return longint'(v);
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ratio = 6; m_main = 5; m_swal = 0; m_pre = 0; m_run = 0; m_mon = 0; m_err = 0;
   endtask

   task automatic model_load();
      int n = bits_q.size();
      int r = 0, nm = 0, s = 0;
      if (bits_q[n-1]) begin
         for (int k = 0; k < 14; k++) r += int'(bits_q[n-2-k]) << k;
         if (r < 6) m_err = 1;
         else begin
            m_ratio = r; m_pre = bits_q[n-16]; m_run = bits_q[n-17]; m_mon = bits_q[n-18];
         end
      end else begin
         for (int k = 0; k < 7; k++)  s  += int'(bits_q[n-2-k]) << k;
         for (int k = 0; k < 11; k++) nm += int'(bits_q[n-9-k]) << k;
         if (nm < 5) m_err = 1;
         else begin m_main = nm; m_swal = s; end
      end
   endtask

   always @(negedge clk) begin
      if (settle > 0) settle--;
      else if (rst_n) chk("R2 per-clock model", act_vec(), exp_vec());
   end

   task automatic sbit(input logic b);
      ser_data = b;
      bits_q.push_back(b);
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic shift_word(input logic [18:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(w[i]);
   endtask

   task automatic le_up();
      ser_le = 1'b1;
      model_load();
      settle = 8;
      repeat (10) @(posedge clk);
   endtask
   task automatic le_down();
      ser_le = 1'b0;
      repeat (6) @(posedge clk);
   endtask

   function automatic logic [18:0] ref_word(input int mon, run, pre, r);
      return {1'b0, mon[0], run[0], pre[0], 14'(r), 1'b1};
   endfunction
   function automatic logic [18:0] div_word(input int nm, s);
      return {11'(nm), 7'(s), 1'b0};
   endfunction

   task automatic load_ref(input int mon, run, pre, r);
      shift_word(ref_word(mon, run, pre, r), 18); le_up(); le_down();
   endtask
   task automatic load_div(input int nm, s);
      shift_word(div_word(nm, s), 19); le_up(); le_down();
   endtask

   task automatic do_reset();
      settle = 1000000;
      rst_n = 1'b0;
      model_reset();
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      settle = 0;
   endtask

   initial begin
      model_reset();
      do_reset();
      @(negedge clk);
      chk("R1 reset ref_ratio", ref_ratio, 6);
      chk("R1 reset main_ratio", main_ratio, 5);
      chk("R1 reset swallow/flags", {swallow, pre_small, run_en, mon_sel, cfg_err}, 0);

      load_ref(1, 1, 0, 1234);
      @(negedge clk);
      chk("R5 ref fields", {mon_sel, run_en, pre_small, ref_ratio}, {3'b110, 14'd1234});
      chk("R3 divider untouched", {main_ratio, swallow}, {11'd5, 7'd0});

      load_div(1000, 77);
      @(negedge clk);
      chk("R6 main_ratio", main_ratio, 1000);
      chk("R6 swallow", swallow, 77);
      chk("R4 ref untouched", ref_ratio, 1234);

      shift_word(div_word(2047, 127), 19);
      @(negedge clk);
      chk("R2 shift without strobe", {main_ratio, swallow}, {11'd1000, 7'd77});

      load_ref(1, 0, 1, 500);
      load_ref(0, 1, 1, 9000);
      @(negedge clk);
      chk("R8 stale top bit ignored", {mon_sel, run_en, pre_small, ref_ratio}, {3'b011, 14'd9000});

      shift_word(ref_word(1, 1, 0, 300), 18);
      le_up();
      sbit(1'b0); sbit(1'b1); sbit(1'b1);
      @(negedge clk);
      chk("R7 no update while strobe held", ref_ratio, 300);
      le_down();
      chk("R7 fields after single transfer", {mon_sel, run_en, pre_small}, 3'b110);

      load_ref(0, 0, 0, 5);
      @(negedge clk);
      chk("R9 rejected ref keeps value", ref_ratio, 300);
      chk("R9 error raised", cfg_err, 1);

      load_ref(1, 1, 1, 6);
      @(negedge clk);
      chk("R12 ratio 6 accepted", ref_ratio, 6);
      chk("R11 error still set", cfg_err, 1);

      load_div(4, 3);
      @(negedge clk);
      chk("R10 rejected main keeps value", {main_ratio, swallow}, {11'd1000, 7'd77});

      load_div(5, 0);
      @(negedge clk);
      chk("R12 main 5 swallow 0 accepted", {main_ratio, swallow}, {11'd5, 7'd0});

      load_ref(0, 1, 0, 16383);
      @(negedge clk);
      chk("R5 max ratio", ref_ratio, 16383);

      do_reset();
      @(negedge clk);
      chk("R11 error cleared by reset", cfg_err, 0);
      chk("R1 second reset ratio", ref_ratio, 6);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule